// File: doc/BRIEF.md
# Maskable Repeating Alarm Comparator

This block watches a running calendar clock and raises a one-cycle interrupt pulse whenever the current time agrees with a programmed alarm. The alarm is held in four byte registers (seconds, minutes, hours, day of month) that a host reaches through a small byte-wide register window. The time itself arrives from an external counter as four BCD bytes, together with a single-cycle strobe that marks each new second; the comparison is made only on that strobe.

Bit 7 of every alarm byte is a mask flag. The pattern of flags picks how often the alarm repeats: with nothing masked it fires once a month, and masking date, then hour, then minute in turn widens it to a daily, hourly or per-minute alarm. Any pattern outside that cascade makes it fire on every second. Each register write goes through a BCD range check for its field, and a write that fails the check leaves the register as it was.

Top module: `repeat_alarm`

## Requirements
- R1: After reset the seconds, minutes and hours alarm registers read 0x00, the date register reads 0x01, and `alarm_irq` is low.
- R2: The register window starts at `BASE_ADDR`: offset 0 is seconds, 1 minutes, 2 hours, 3 date. A read returns the full stored byte including bit 7; an address outside the four-byte window reads 0x00 and a write to it changes no register.
- R3: A seconds or minutes write is stored (all 8 bits) only when bits 6:0 form a BCD value 0 to 59 with a units digit (bits 3:0) no greater than 9; otherwise the register keeps its previous value.
- R4: An hours write is stored (all 8 bits) only when bits 5:0 form a BCD value 0 to 23 with a units digit no greater than 9; otherwise it is dropped.
- R5: A date write is stored (all 8 bits) only when bits 5:0 form a nonzero BCD value with a units digit no greater than 9; otherwise it is dropped.
- R6: With no mask bit set, a tick raises the interrupt when seconds bits 6:0, minutes bits 6:0, hours bits 5:0 and date bits 5:0 of the current time all equal the alarm; other bits of the time inputs are ignored.
- R7: With only the date mask set, a tick raises the interrupt when seconds, minutes and hours agree, whatever the date.
- R8: With only the date and hours masks set, a tick raises the interrupt when seconds and minutes agree.
- R9: With date, hours and minutes masked and seconds unmasked, a tick raises the interrupt when seconds agree.
- R10: Any other mask pattern raises the interrupt on every tick.
- R11: `alarm_irq` is high for exactly one cycle, in the cycle after a qualifying tick, and is never raised without a tick, even when the time matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe marking a new second |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| reg_addr | input | ADDR_W | Register address, shared by read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| alarm_irq | output | 1 | Alarm interrupt pulse |

## Verification
The bench builds the block with a six-bit address and a window base of 0x32, which is not a multiple of four, so the window edges at 0x31 and 0x36 and the offset subtraction are exercised rather than a simple low-bit decode. A table of accepted and rejected writes probes each field's range limits, and directed ticks then walk the mask cascade from monthly to per-second, including time inputs whose spare high bits are set.

// File: rtl/ra_pkg.sv
package ra_pkg;

    localparam int NUM_FIELDS  = 4;
    localparam int FIELD_IDX_W = $clog2(NUM_FIELDS);
    localparam int MASK_BIT    = 7;

    // Field order is fixed by the register window layout.
    typedef enum logic [FIELD_IDX_W-1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2,
        FLD_DATE = 2'd3
    } field_e;

    typedef enum logic [2:0] {
        RATE_MONTH,
        RATE_DAY,
        RATE_HOUR,
        RATE_MINUTE,
        RATE_SECOND
    } rate_e;

    typedef logic [NUM_FIELDS-1:0][7:0] field_vec_t;

    // Bits of each field that carry the BCD value.
    function automatic logic [7:0] field_bits(input int idx);
        case (idx)
            0, 1:    return 8'h7F;
            default: return 8'h3F;
        endcase
    endfunction

    function automatic logic [7:0] reset_value(input int idx);
        return (idx == int'(FLD_DATE)) ? 8'h01 : 8'h00;
    endfunction

    function automatic logic write_ok(input int idx, input logic [7:0] d);
        logic [7:0] v;
        int         n;
        v = d & field_bits(idx);
        if (v[3:0] > 4'd9) return 1'b0;
        n = int'(v[7:4]) * 10 + int'(v[3:0]);
        case (idx)
            0, 1:    return n <= 59;
            2:       return n <= 23;
            default: return n != 0;
        endcase
    endfunction

    // Mask vector order: {date, hour, min, sec}.
    function automatic rate_e decode_rate(input logic [NUM_FIELDS-1:0] m);
        case (m)
            4'b0000: return RATE_MONTH;
            4'b1000: return RATE_DAY;
            4'b1100: return RATE_HOUR;
            4'b1110: return RATE_MINUTE;
            default: return RATE_SECOND;
        endcase
    endfunction

endpackage

// File: rtl/ra_addr_decode.sv
module ra_addr_decode
    import ra_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 4'h4
) (
    input  logic [ADDR_W-1:0]      addr,
    output logic                   hit,
    output logic [FIELD_IDX_W-1:0] idx
);
    localparam logic [ADDR_W:0] SPAN = (ADDR_W + 1)'(NUM_FIELDS);

    logic [ADDR_W:0] diff;

    // One extra bit catches addresses below the base.
    assign diff = {1'b0, addr} - {1'b0, BASE_ADDR};
    assign hit  = !diff[ADDR_W] && (diff < SPAN);
    assign idx  = diff[FIELD_IDX_W-1:0];

endmodule

// File: rtl/ra_regfile.sv
module ra_regfile
    import ra_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic                   hit,
    input  logic [FIELD_IDX_W-1:0] idx,
    input  logic [7:0]             wr_data,
    output field_vec_t             regs,
    output logic [7:0]             rd_data
);
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        logic [7:0] q;
        logic       accept;

        assign accept = wr_en && hit && (idx == FIELD_IDX_W'(f))
                        && write_ok(f, wr_data);

        always_ff @(posedge clk) begin
            if (rst)
                q <= reset_value(f);
            else if (accept)
                q <= wr_data;
        end

        assign regs[f] = q;
    end

    assign rd_data = hit ? regs[idx] : 8'h00;

endmodule

// File: rtl/ra_match.sv
module ra_match
    import ra_pkg::*;
(
    input  field_vec_t regs,
    input  field_vec_t now,
    output rate_e      rate,
    output logic       match
);
    logic [NUM_FIELDS-1:0] eq;
    logic [NUM_FIELDS-1:0] masks;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_cmp
        assign eq[f]    = ((regs[f] ^ now[f]) & field_bits(f)) == 8'h00;
        assign masks[f] = regs[f][MASK_BIT];
    end

    assign rate = decode_rate(masks);

    always_comb begin
        case (rate)
            RATE_MONTH:  match = &eq;
            RATE_DAY:    match = eq[FLD_SEC] & eq[FLD_MIN] & eq[FLD_HOUR];
            RATE_HOUR:   match = eq[FLD_SEC] & eq[FLD_MIN];
            RATE_MINUTE: match = eq[FLD_SEC];
            default:     match = 1'b1;
        endcase
    end

endmodule

// File: rtl/ra_pulse.sv
module ra_pulse (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic match,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else
            irq <= tick && match;
    end

endmodule

// File: rtl/repeat_alarm.sv
module repeat_alarm
    import ra_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 4'h4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [7:0]        cur_sec,
    input  logic [7:0]        cur_min,
    input  logic [7:0]        cur_hour,
    input  logic [7:0]        cur_date,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              alarm_irq
);
    logic                   hit;
    logic [FIELD_IDX_W-1:0] idx;
    field_vec_t             regs;
    field_vec_t             now;
    rate_e                  rate;
    logic                   match;

    assign now[FLD_SEC]  = cur_sec;
    assign now[FLD_MIN]  = cur_min;
    assign now[FLD_HOUR] = cur_hour;
    assign now[FLD_DATE] = cur_date;

    ra_addr_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_dec (
        .addr (reg_addr),
        .hit  (hit),
        .idx  (idx)
    );

    ra_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .hit     (hit),
        .idx     (idx),
        .wr_data (reg_wdata),
        .regs    (regs),
        .rd_data (reg_rdata)
    );

    ra_match u_match (
        .regs  (regs),
        .now   (now),
        .rate  (rate),
        .match (match)
    );

    ra_pulse u_pulse (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .match (match),
        .irq   (alarm_irq)
    );

endmodule

// File: rtl/ra_checker.sv
module ra_checker
    import ra_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   tick,
    input logic                   reg_wr,
    input logic [7:0]             reg_wdata,
    input logic                   hit,
    input logic [FIELD_IDX_W-1:0] idx,
    input field_vec_t             regs,
    input logic [7:0]             cur_date,
    input logic                   alarm_irq
);
    logic [NUM_FIELDS-1:0] m;
    assign m = {regs[3][7], regs[2][7], regs[1][7], regs[0][7]};

    // R11
    irq_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |-> $past(tick));

    // R11
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm_irq && !tick) |=> !alarm_irq);

    // R3
    sec_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && hit && idx == 2'd0 &&
         (reg_wdata[6:4] > 3'd5 || reg_wdata[3:0] > 4'd9)) |=> $stable(regs[0]));

    // R5
    date_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && hit && idx == 2'd3 && reg_wdata[5:0] == 6'd0) |=> $stable(regs[3]));

    // R2
    miss_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !hit) |=> $stable(regs));

    // R10
    every_second_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && m != 4'b0000 && m != 4'b1000 && m != 4'b1100 && m != 4'b1110)
        |=> alarm_irq);

    // R6
    month_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && m == 4'b0000 && cur_date[5:0] != regs[3][5:0]) |=> !alarm_irq);

endmodule

bind repeat_alarm ra_checker #(.ADDR_W(ADDR_W)) u_ra_checker (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .hit       (hit),
    .idx       (idx),
    .regs      (regs),
    .cur_date  (cur_date),
    .alarm_irq (alarm_irq)
);

// File: tb/repeat_alarm_bench.sv
module repeat_alarm_bench;
    localparam int             AW   = 6;
    localparam logic [AW-1:0]  BASE = 6'h32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic [7:0]    cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00, cur_date = 8'h15;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = 8'h00;
    logic [7:0]    reg_rdata;
    logic          alarm_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    repeat_alarm #(.ADDR_W(AW), .BASE_ADDR(BASE)) u_repeat_alarm (
        .clk(clk), .rst(rst), .tick(tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .alarm_irq(alarm_irq)
    );

    // {offset[1:0], write data, expected readback}
    localparam int NW = 20;
    localparam logic [17:0] WTAB [NW] = '{
        {2'd0, 8'h59, 8'h59}, {2'd0, 8'h60, 8'h59}, {2'd0, 8'h5A, 8'h59},
        {2'd0, 8'hD9, 8'hD9}, {2'd0, 8'h00, 8'h00},
        {2'd1, 8'h45, 8'h45}, {2'd1, 8'h7F, 8'h45}, {2'd1, 8'h8A, 8'h45},
        {2'd2, 8'h23, 8'h23}, {2'd2, 8'h24, 8'h23}, {2'd2, 8'h1A, 8'h23},
        {2'd2, 8'h89, 8'h89}, {2'd2, 8'h00, 8'h00},
        {2'd3, 8'h31, 8'h31}, {2'd3, 8'h00, 8'h31}, {2'd3, 8'h80, 8'h31},
        {2'd3, 8'h3A, 8'h31}, {2'd3, 8'h39, 8'h39}, {2'd3, 8'h15, 8'h15},
        {2'd1, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic set_alarm(input logic [7:0] s, m, h, d);
        wr(BASE + 6'd0, s); wr(BASE + 6'd1, m);
        wr(BASE + 6'd2, h); wr(BASE + 6'd3, d);
    endtask

    task automatic tick_check(input logic [7:0] s, m, h, d, input logic exp, input string req);
        @(negedge clk);
        cur_sec = s; cur_min = m; cur_hour = h; cur_date = d; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check(req, {7'd0, alarm_irq}, {7'd0, exp});
        @(negedge clk);
        check("R11", {7'd0, alarm_irq}, 8'h00);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd_check(BASE + 6'd0, 8'h00, "R1");
        rd_check(BASE + 6'd1, 8'h00, "R1");
        rd_check(BASE + 6'd2, 8'h00, "R1");
        rd_check(BASE + 6'd3, 8'h01, "R1");
        check("R1", {7'd0, alarm_irq}, 8'h00);

        // R3 R4 R5 write range table
        for (int i = 0; i < NW; i++) begin
            logic [1:0] off;
            off = WTAB[i][17:16];
            wr(BASE + AW'(off), WTAB[i][15:8]);
            rd_check(BASE + AW'(off), WTAB[i][7:0],
                     off < 2'd2 ? "R3" : (off == 2'd2 ? "R4" : "R5"));
        end

        // R2 window edges
        rd_check(BASE - 6'd1, 8'h00, "R2");
        rd_check(BASE + 6'd4, 8'h00, "R2");
        wr(BASE - 6'd1, 8'h11);
        wr(BASE + 6'd4, 8'h22);
        rd_check(BASE + 6'd0, 8'h00, "R2");
        rd_check(BASE + 6'd1, 8'h00, "R2");
        rd_check(BASE + 6'd2, 8'h00, "R2");
        rd_check(BASE + 6'd3, 8'h15, "R2");

        // R6 monthly
        set_alarm(8'h10, 8'h20, 8'h05, 8'h12);
        tick_check(8'h90, 8'h20, 8'h45, 8'h12, 1'b1, "R6");
        tick_check(8'h10, 8'h20, 8'h05, 8'h13, 1'b0, "R6");
        tick_check(8'h11, 8'h20, 8'h05, 8'h12, 1'b0, "R6");

        // R11 match without tick
        @(negedge clk);
        cur_sec = 8'h10; cur_min = 8'h20; cur_hour = 8'h05; cur_date = 8'h12;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R11", {7'd0, alarm_irq}, 8'h00);
        end

        // R7 daily
        wr(BASE + 6'd3, 8'h92);
        tick_check(8'h10, 8'h20, 8'h05, 8'h13, 1'b1, "R7");
        tick_check(8'h10, 8'h20, 8'h06, 8'h13, 1'b0, "R7");

        // R8 hourly
        wr(BASE + 6'd2, 8'h85);
        tick_check(8'h10, 8'h20, 8'h06, 8'h13, 1'b1, "R8");
        tick_check(8'h10, 8'h21, 8'h06, 8'h13, 1'b0, "R8");

        // R9 per minute
        wr(BASE + 6'd1, 8'hA0);
        tick_check(8'h10, 8'h21, 8'h06, 8'h13, 1'b1, "R9");
        tick_check(8'h11, 8'h21, 8'h06, 8'h13, 1'b0, "R9");

        // R10 other patterns
        wr(BASE + 6'd0, 8'h90);
        tick_check(8'h11, 8'h21, 8'h06, 8'h13, 1'b1, "R10");
        wr(BASE + 6'd1, 8'h20);
        tick_check(8'h33, 8'h44, 8'h07, 8'h01, 1'b1, "R10");
        wr(BASE + 6'd2, 8'h05);
        wr(BASE + 6'd3, 8'h12);
        tick_check(8'h33, 8'h44, 8'h07, 8'h01, 1'b1, "R10");

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        rd_check(BASE + 6'd0, 8'h00, "R1");
        rd_check(BASE + 6'd3, 8'h01, "R1");

        $display("%0d/%0d checks passed", checks - fails, checks);
        done = 1;
        $finish;
    end

endmodule